// File: doc/BRIEF.md
# General-Purpose Pin Port Register File

This block is a byte-addressed register file that owns eighteen general-purpose pins. For each pin it holds a direction bit, an output latch, a two-bit pull selection and a debounce enable. On read it returns the pin levels after a two-flop synchronizer and an optional per-pin debounce filter. A control register holds a module-on bit, which gates the pad drivers and the input readback, and two card-detect enable bits that apply only to pins 0 and 1.

Software reaches the block over a plain single-cycle bus with an address, write data, a write strobe, a read strobe and read data. Read data is combinational from the address while the read strobe is high and is zero otherwise. The output latch cannot be written directly. Software sets pins through a set register and clears them through a clear register, so pins are changed without a read-modify-write. Pad control leaves the block as plain vectors: output enable, output value, pull-up and pull-down.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every register is 0, every pad output is 0 and every mapped address reads 0.
- R2: Address 0x00 is the control register. Bit 2 turns the module on, and bits 0 and 1 enable card detect for pins 0 and 1. cd_en_o equals bits 1:0 while bit 2 is 1 and is 0 otherwise. Bits 7:3 read 0.
- R3: Addresses 0x04 to 0x06 hold the direction bits. Pin n sits at address 0x04+n/8, bit n%8, and a 1 makes it an output: pad_oe_o[n] = direction bit AND module-on. Direction bits change only on a write to their own address.
- R4: A write to 0x0A+b (the set bank) sets to 1 every output latch bit of bank b whose written bit is 1 and leaves the others unchanged. The set and clear addresses read 0.
- R5: A write to 0x0D+b (the clear bank) clears to 0 every output latch bit of bank b whose written bit is 1 and leaves the others unchanged.
- R6: The output latch reads back at 0x07 to 0x09 in the same bank layout and drives pad_out_o.
- R7: Addresses 0x01 to 0x03 return the synchronized pin levels in the bank layout. With debounce off, a pin change is visible on the third rising edge after it, and not before.
- R8: Addresses 0x10 to 0x12 hold the debounce enables. On an enabled pin, a new level is accepted only after it has stayed stable for DEB_CYCLES cycles, so shorter pulses are dropped.
- R9: Addresses 0x14 to 0x18 hold the pull selections, four pins per byte. Bit 2k is pull-down and bit 2k+1 is pull-up for pin 4*(addr-0x14)+k. They drive pad_pd_o and pad_pu_o.
- R10: When both pull bits of a pin are 1, pad_pd_o is 1 and pad_pu_o is 0.
- R11: Bits of the last data bank and the last pull bank that have no pin behind them read 0 and ignore writes. Unmapped addresses read 0.
- R12: While module-on is 0, pad_oe_o and cd_en_o are 0 and the data-in addresses read 0. Every register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register byte address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, takes effect on the rising edge |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational, 0 when not reading |
| pad_in_i | input | 18 | Asynchronous pin levels |
| pad_out_o | output | 18 | Output latch value |
| pad_oe_o | output | 18 | Output enable per pin |
| pad_pu_o | output | 18 | Pull-up enable per pin |
| pad_pd_o | output | 18 | Pull-down enable per pin |
| cd_en_o | output | 2 | Card-detect enable for pins 0 and 1 |

## Verification
The assertions assume that the write strobe is a clean single-cycle qualifier, that the address is stable while it is high, and that only one address is decoded at a time. The bench drives every bus input on the falling edge and holds each strobe for exactly one rising edge. Pin inputs are treated as asynchronous only up to the synchronizer. The bench changes them on falling edges and counts rising edges from that point, so both the three-edge latency and the debounce window can be checked at exact cycles. It uses a debounce window of 16 to keep the run short.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W    = 5;
  localparam int CTRL_ADDR = 0;
  localparam int DIN_BASE  = 1;
  localparam int DIR_BASE  = 4;
  localparam int OUT_BASE  = 7;
  localparam int SET_BASE  = 10;
  localparam int CLR_BASE  = 13;
  localparam int DEB_BASE  = 16;
  localparam int PULL_BASE = 20;
  localparam int MAX_DATA_BANKS = 3;
  localparam int MAX_PULL_BANKS = 5;

  localparam int CTRL_ON_BIT = 2;

  function automatic logic [63:0] low_ones(input int n);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_port_pkg::*;
#(
  parameter int DATA_BANKS = 3,
  parameter int PULL_BANKS = 5
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output logic                  ctrl_hit_o,
  output logic [DATA_BANKS-1:0] din_hit_o,
  output logic [DATA_BANKS-1:0] dir_hit_o,
  output logic [DATA_BANKS-1:0] out_hit_o,
  output logic [DATA_BANKS-1:0] set_hit_o,
  output logic [DATA_BANKS-1:0] clr_hit_o,
  output logic [DATA_BANKS-1:0] deb_hit_o,
  output logic [PULL_BANKS-1:0] pull_hit_o
);
  assign ctrl_hit_o = (addr_i == ADDR_W'(CTRL_ADDR));

  for (genvar b = 0; b < DATA_BANKS; b++) begin : g_data
    assign din_hit_o[b] = (addr_i == ADDR_W'(DIN_BASE + b));
    assign dir_hit_o[b] = (addr_i == ADDR_W'(DIR_BASE + b));
    assign out_hit_o[b] = (addr_i == ADDR_W'(OUT_BASE + b));
    assign set_hit_o[b] = (addr_i == ADDR_W'(SET_BASE + b));
    assign clr_hit_o[b] = (addr_i == ADDR_W'(CLR_BASE + b));
    assign deb_hit_o[b] = (addr_i == ADDR_W'(DEB_BASE + b));
  end

  for (genvar b = 0; b < PULL_BANKS; b++) begin : g_pull
    assign pull_hit_o[b] = (addr_i == ADDR_W'(PULL_BASE + b));
  end
endmodule

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter #(
  parameter int DEB_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic deb_en_i,
  output logic level_o
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic          s1_q, s2_q, lvl_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      if (!deb_en_i) begin
        lvl_q <= s2_q;
        cnt_q <= '0;
      end else if (s2_q != lvl_q) begin
        if (cnt_q == CW'(DEB_CYCLES - 1)) begin
          lvl_q <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign level_o = lvl_q;

  // debounced level moves only at the end of a full stable window
  assert_deb_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deb_en_i && $past(deb_en_i) && !$stable(lvl_q)) |-> ($past(cnt_q) == CW'(DEB_CYCLES - 1)));

  assert_deb_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(DEB_CYCLES));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS   = 18,
  parameter int DEB_CYCLES = 1024
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [7:0]          wdata_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  output logic [7:0]          rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_pu_o,
  output logic [NUM_PINS-1:0] pad_pd_o,
  output logic [1:0]          cd_en_o
);
  localparam int DATA_BANKS = (NUM_PINS + 7) / 8;
  localparam int PULL_BANKS = (NUM_PINS + 3) / 4;
  localparam int DW = DATA_BANKS * 8;
  localparam int PW = PULL_BANKS * 8;
  localparam logic [DW-1:0] PIN_MASK  = DW'(low_ones(NUM_PINS));
  localparam logic [PW-1:0] PULL_MASK = PW'(low_ones(2 * NUM_PINS));

  logic                  ctrl_hit;
  logic [DATA_BANKS-1:0] din_hit, dir_hit, out_hit, set_hit, clr_hit, deb_hit;
  logic [PULL_BANKS-1:0] pull_hit;

  gpio_addr_dec #(.DATA_BANKS(DATA_BANKS), .PULL_BANKS(PULL_BANKS)) i_dec (
    .addr_i     (addr_i),
    .ctrl_hit_o (ctrl_hit),
    .din_hit_o  (din_hit),
    .dir_hit_o  (dir_hit),
    .out_hit_o  (out_hit),
    .set_hit_o  (set_hit),
    .clr_hit_o  (clr_hit),
    .deb_hit_o  (deb_hit),
    .pull_hit_o (pull_hit)
  );

  logic [2:0]    ctrl_q, ctrl_d;
  logic [DW-1:0] dir_q, dir_d, out_q, out_d, deb_q, deb_d, lvl;
  logic [PW-1:0] pull_q, pull_d;
  logic          mod_on;

  assign mod_on = ctrl_q[CTRL_ON_BIT];

  always_comb begin
    ctrl_d = ctrl_q;
    dir_d  = dir_q;
    out_d  = out_q;
    deb_d  = deb_q;
    pull_d = pull_q;
    if (wr_en_i) begin
      if (ctrl_hit) ctrl_d = wdata_i[2:0];
      for (int b = 0; b < DATA_BANKS; b++) begin
        if (dir_hit[b]) dir_d[b*8 +: 8] = wdata_i;
        if (set_hit[b]) out_d[b*8 +: 8] = out_q[b*8 +: 8] | wdata_i;
        if (clr_hit[b]) out_d[b*8 +: 8] = out_q[b*8 +: 8] & ~wdata_i;
        if (deb_hit[b]) deb_d[b*8 +: 8] = wdata_i;
      end
      for (int b = 0; b < PULL_BANKS; b++) begin
        if (pull_hit[b]) pull_d[b*8 +: 8] = wdata_i;
      end
    end
    dir_d  = dir_d & PIN_MASK;
    out_d  = out_d & PIN_MASK;
    deb_d  = deb_d & PIN_MASK;
    pull_d = pull_d & PULL_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      deb_q  <= '0;
      pull_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      dir_q  <= dir_d;
      out_q  <= out_d;
      deb_q  <= deb_d;
      pull_q <= pull_d;
    end
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    gpio_pin_filter #(.DEB_CYCLES(DEB_CYCLES)) i_filt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (pad_in_i[n]),
      .deb_en_i (deb_q[n]),
      .level_o  (lvl[n])
    );
    // pull-down wins when both are selected
    assign pad_pd_o[n] = pull_q[2*n];
    assign pad_pu_o[n] = pull_q[2*n+1] & ~pull_q[2*n];
  end

  if (DW > NUM_PINS) begin : g_lvl_pad
    assign lvl[DW-1:NUM_PINS] = '0;
  end

  assign pad_out_o = out_q[NUM_PINS-1:0];
  assign pad_oe_o  = dir_q[NUM_PINS-1:0] & {NUM_PINS{mod_on}};
  assign cd_en_o   = ctrl_q[1:0] & {2{mod_on}};

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (ctrl_hit) rdata_o = {5'b0, ctrl_q};
      for (int b = 0; b < DATA_BANKS; b++) begin
        if (din_hit[b]) rdata_o = lvl[b*8 +: 8] & {8{mod_on}};
        if (dir_hit[b]) rdata_o = dir_q[b*8 +: 8];
        if (out_hit[b]) rdata_o = out_q[b*8 +: 8];
        if (deb_hit[b]) rdata_o = deb_q[b*8 +: 8];
      end
      for (int b = 0; b < PULL_BANKS; b++) begin
        if (pull_hit[b]) rdata_o = pull_q[b*8 +: 8];
      end
    end
  end

  assert_dec_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_hit, din_hit, dir_hit, out_hit, set_hit, clr_hit, deb_hit, pull_hit}));

  assert_set_bank0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && set_hit[0]) |=> ((pad_out_o[7:0] & $past(wdata_i)) == $past(wdata_i)));

  assert_clr_bank0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && clr_hit[0]) |=> ((pad_out_o[7:0] & $past(wdata_i)) == 8'h00));

  assert_dir_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (|dir_hit)) |=> $stable(dir_q));

  assert_off_gates_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ctrl_hit && !wdata_i[CTRL_ON_BIT]) |=> (pad_oe_o == '0 && cd_en_o == 2'b00));

  assert_pull_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_pd_o) == '0);
endmodule

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;
  localparam int NP  = 18;
  localparam int DEB = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_pu, pad_pd;
  logic [1:0]    cd_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  gpio_port_regs #(.NUM_PINS(NP), .DEB_CYCLES(DEB)) i_gpio_port_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pu_o(pad_pu),
    .pad_pd_o(pad_pd), .cd_en_o(cd_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, {24'h0, d}, {24'h0, exp});
  endtask

  task automatic t_reset;
    for (int a = 0; a < 32; a++) rd_chk("R1 reset read", 5'(a), 8'h00);
    chk("R1 reset pad_oe", 32'(pad_oe), 0);
    chk("R1 reset pad_out", 32'(pad_out), 0);
    chk("R1 reset pulls", 32'(pad_pu | pad_pd), 0);
    chk("R1 reset cd_en", 32'(cd_en), 0);
  endtask

  task automatic t_ctrl;
    wr(5'h00, 8'hFF);
    rd_chk("R2 ctrl upper bits read 0", 5'h00, 8'h07);
    chk("R2 cd_en when on", 32'(cd_en), 3);
    wr(5'h00, 8'h03);
    chk("R2 cd_en gated when off", 32'(cd_en), 0);
    rd_chk("R2 ctrl keeps cd bits", 5'h00, 8'h03);
    wr(5'h00, 8'h06);
    chk("R2 cd_en pin1 only", 32'(cd_en), 2);
    wr(5'h00, 8'h04);
  endtask

  task automatic t_dir;
    wr(5'h04, 8'hA5);
    wr(5'h06, 8'hFF);
    rd_chk("R3 dir bank0", 5'h04, 8'hA5);
    rd_chk("R11 dir last bank masked", 5'h06, 8'h03);
    chk("R3 pad_oe", 32'(pad_oe), 32'h300A5);
    wr(5'h05, 8'h00);
    rd_chk("R3 dir bank0 untouched", 5'h04, 8'hA5);
  endtask

  task automatic t_set_clr;
    wr(5'h0B, 8'h0F);
    rd_chk("R4 set bank1", 5'h08, 8'h0F);
    wr(5'h0B, 8'hF0);
    rd_chk("R4 set keeps zero bits", 5'h08, 8'hFF);
    wr(5'h0E, 8'h3C);
    rd_chk("R5 clear bank1", 5'h08, 8'hC3);
    chk("R6 pad_out bank1", 32'(pad_out[15:8]), 32'hC3);
    wr(5'h0E, 8'h00);
    rd_chk("R5 clear zero no effect", 5'h08, 8'hC3);
    rd_chk("R4 set reg reads 0", 5'h0B, 8'h00);
    rd_chk("R5 clear reg reads 0", 5'h0E, 8'h00);
    wr(5'h0C, 8'hFF);
    rd_chk("R11 out last bank masked", 5'h09, 8'h03);
    wr(5'h0A, 8'h81);
    chk("R6 pad_out full", 32'(pad_out), 32'h3C381);
  endtask

  task automatic t_pull;
    wr(5'h14, 8'h1B);
    rd_chk("R9 pull bank0 read", 5'h14, 8'h1B);
    chk("R9 pad_pd pins 0-3", 32'(pad_pd[3:0]), 32'h5);
    chk("R10 pad_pu pins 0-3", 32'(pad_pu[3:0]), 32'h2);
    wr(5'h18, 8'hFF);
    rd_chk("R11 pull last bank masked", 5'h18, 8'h0F);
    chk("R10 both set pd wins", 32'({pad_pd[17:16], pad_pu[17:16]}), 32'hC);
    wr(5'h16, 8'h22);
    chk("R9 pull bank2 pu", 32'(pad_pu[11:8]), 32'h5);
  endtask

  task automatic t_din;
    logic [7:0] d;
    @(negedge clk);
    pad_in = 18'h2A53C;
    repeat (2) @(posedge clk);
    rd(5'h01, d);
    chk("R7 not yet after two edges", 32'(d), 32'h00);
    @(posedge clk);
    rd_chk("R7 bank0 after three edges", 5'h01, 8'h3C);
    rd_chk("R7 bank1", 5'h02, 8'hA5);
    rd_chk("R7 bank2", 5'h03, 8'h02);
    rd_chk("R11 unmapped 0x13", 5'h13, 8'h00);
    rd_chk("R11 unmapped 0x1F", 5'h1F, 8'h00);
  endtask

  task automatic t_off;
    wr(5'h00, 8'h00);
    rd_chk("R12 din reads 0 when off", 5'h02, 8'h00);
    chk("R12 pad_oe off", 32'(pad_oe), 0);
    rd_chk("R12 dir kept", 5'h04, 8'hA5);
    wr(5'h04, 8'h11);
    chk("R12 pad_oe still off", 32'(pad_oe), 0);
    wr(5'h00, 8'h04);
    chk("R12 pad_oe back on", 32'(pad_oe), 32'h30011);
    rd_chk("R12 din back on", 5'h02, 8'hA5);
  endtask

  task automatic t_deb;
    logic [7:0] d;
    wr(5'h10, 8'h01);
    rd_chk("R8 deb enable read", 5'h10, 8'h01);
    @(negedge clk);
    pad_in = '0;
    repeat (DEB + 8) @(posedge clk);
    rd_chk("R8 baseline low", 5'h01, 8'h00);
    @(negedge clk);
    pad_in[0] = 1'b1; pad_in[1] = 1'b1;
    repeat (4) @(posedge clk);
    rd(5'h01, d);
    chk("R8 short wait: pin0 filtered, pin1 passes", 32'(d), 32'h02);
    @(negedge clk);
    pad_in[0] = 1'b0;
    repeat (DEB + 10) @(posedge clk);
    rd(5'h01, d);
    chk("R8 glitch dropped", 32'(d), 32'h02);
    @(negedge clk);
    pad_in[0] = 1'b1;
    repeat (DEB - 4) @(posedge clk);
    rd(5'h01, d);
    chk("R8 inside window", 32'(d), 32'h02);
    repeat (10) @(posedge clk);
    rd(5'h01, d);
    chk("R8 accepted after window", 32'(d), 32'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_dir();
    t_set_clr();
    t_pull();
    t_din();
    t_off();
    t_deb();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule